// File: doc/BRIEF.md
# Serial Interface Control Register Sequencer

This block is the processor-facing register front end of a programmable asynchronous serial interface. It decodes a chip select, a control/data selector and active-low read and write strobes. Control writes all use one address, so an initialization state machine decides where each one goes. The first control write after any reset is taken as the format (mode) byte. Every later control write is taken as a command byte, until a command asks for an internal reset. Reads at the control address return a status byte. Reads at the data address return the received byte. Writes at the data address hand a byte to the transmit datapath.

The block drives the active-low modem handshake outputs (terminal-ready and send-request). It also drives the transmit and receive enables, a break request, a one-cycle error-clear pulse, a one-cycle internal-reset pulse for the datapaths, and the decoded character format. It keeps the three sticky line-error flags (parity, overrun, framing), which the serial datapath sets with single-cycle pulses.

The state machine has two states. In `SEQ_AWAIT_MODE` the next control write stores the mode byte and moves to `SEQ_RUN`. In `SEQ_RUN` a control write with bit 6 clear stores a command and stays in `SEQ_RUN`. A control write with bit 6 set clears the mode, command and error state, pulses the internal reset and returns to `SEQ_AWAIT_MODE`. Hardware reset also enters `SEQ_AWAIT_MODE`.

Top module: `usart_ctrl_seq`

## Requirements
- R1: After synchronous active-high reset, dtr_n and rts_n are 1, tx_en, rx_en and send_brk are 0, dout_oe is 0, and the sequencer awaits a mode byte.
- R2: The first control write (cs_n=0, cd_sel=1) after a reset is stored as the mode byte. Every later control write with bit 6 clear is stored as a command and leaves the mode outputs unchanged.
- R3: A command with bit 6 set clears the command outputs, the mode fields and the error flags. It pulses dp_rst high for exactly one cycle, and the next control write is stored as a mode byte.
- R4: Mode decode. Bits 1:0 give baud_mul: 00 gives 0 (synchronous), 01 gives 1, 10 gives 16, 11 gives 64. Bits 3:2 give char_bits = 5 + value. Bit 4 gives par_en. Bit 5 gives par_even (1 = even, 0 = odd). Bits 7:6 give stop_halves: 11 gives 4, 10 gives 3, 01 or 00 gives 2. Byte 0xDA decodes to 16, 7 bits, parity on, odd, 4 half-bits.
- R5: Command decode. Bit 0 drives tx_en, bit 2 drives rx_en and bit 3 drives send_brk. Bit 1 set drives dtr_n low and bit 5 set drives rts_n low. Outputs follow the most recent command.
- R6: A status read (cs_n=0, cd_sel=1, rd_n=0) sets dout_oe and returns {~dsr_n, 0, framing, overrun, parity, tx_empty_in, rx_rdy_in, tx_rdy_in} (bit 7 down to bit 0).
- R7: A data read (cs_n=0, cd_sel=0, rd_n=0) returns rx_byte with dout_oe high, and pulses rx_rd in the first cycle of the strobe.
- R8: A data write (cs_n=0, cd_sel=0) pulses tx_load for one cycle in the cycle after the first strobe cycle, with tx_byte equal to the written byte. Mode and command outputs stay unchanged.
- R9: While cs_n is 1, strobes have no effect, dout_oe stays 0, and tx_load and rx_rd stay 0.
- R10: Each error flag is set by its set pulse and holds until a command with bit 4 set. That command clears all three flags at once and pulses err_clr in the next cycle. A set pulse in the same cycle as the clear wins.
- R11: A strobe held low for several cycles performs exactly one write or one read action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cd_sel | input | 1 | 1 selects control/status, 0 selects data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor |
| dout_oe | output | 1 | High while dout should be driven onto the bus |
| tx_rdy_in | input | 1 | Transmit buffer free, from datapath |
| tx_empty_in | input | 1 | Transmit shifter empty, from datapath |
| rx_rdy_in | input | 1 | Received byte available, from datapath |
| rx_byte | input | 8 | Received byte from datapath |
| par_err_set | input | 1 | Parity error pulse |
| ovr_err_set | input | 1 | Overrun error pulse |
| frm_err_set | input | 1 | Framing error pulse |
| dsr_n | input | 1 | Modem data-set-ready, active low |
| dtr_n | output | 1 | Terminal-ready to modem, active low |
| rts_n | output | 1 | Send-request to modem, active low |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| send_brk | output | 1 | Force break on the line |
| err_clr | output | 1 | One-cycle error-clear pulse |
| dp_rst | output | 1 | One-cycle internal reset for the datapaths |
| tx_load | output | 1 | One-cycle load strobe for the transmit buffer |
| tx_byte | output | 8 | Byte for the transmit buffer |
| rx_rd | output | 1 | One-cycle received-byte consumed strobe |
| baud_mul | output | 7 | Clock-to-baud factor, 0 for synchronous |
| char_bits | output | 4 | Data bits per character |
| stop_halves | output | 3 | Stop length in half-bit units |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity when 1 |

## Verification
Two events can land in the same clock edge: a parity error pulse from the datapath and an error-reset command from the processor. The bench provokes this by raising par_err_set in the very cycle the command strobe fires, after setting all three flags. It then reads status and expects the parity flag to survive while the overrun and framing flags are cleared, and it expects err_clr to pulse anyway. The other shared-edge case is an internal-reset command that also carries enable, terminal-ready and send-request bits. The bench judges it by dp_rst rising while every command output stays inactive.

// File: rtl/usart_ctrl_pkg.sv
package usart_ctrl_pkg;
    localparam int BYTE_W   = 8;
    localparam int MUL_W    = 7;
    localparam int CHAR_W   = 4;
    localparam int STOP_W   = 3;
    localparam int MIN_CHAR = 5;

    // command bit positions (decoded by the sequencer and register file)
    localparam int CB_TXEN = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RXEN = 2;
    localparam int CB_BRK  = 3;
    localparam int CB_ERST = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IRST = 6;

    typedef enum logic [0:0] {
        SEQ_AWAIT_MODE = 1'b0,
        SEQ_RUN        = 1'b1
    } seq_state_t;

    // format byte layout, MSB first
    typedef struct packed {
        logic [1:0] stop;
        logic       even;
        logic       par;
        logic [1:0] len;
        logic [1:0] fact;
    } mode_t;

    typedef struct packed {
        logic rts;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_t;
endpackage

// File: rtl/usart_bus_decode.sv
module usart_bus_decode (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic cd_sel,
    input  logic rd_n,
    input  logic wr_n,
    output logic ctrl_wr,
    output logic data_wr,
    output logic data_rd
);
    logic wr_n_q, rd_n_q;
    logic wr_edge, rd_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            rd_n_q <= 1'b1;
        end else begin
            wr_n_q <= wr_n | cs_n;
            rd_n_q <= rd_n | cs_n;
        end
    end

    always_comb begin
        wr_edge = !cs_n && !wr_n && wr_n_q;
        rd_edge = !cs_n && !rd_n && rd_n_q;
        ctrl_wr = wr_edge && cd_sel;
        data_wr = wr_edge && !cd_sel;
        data_rd = rd_edge && !cd_sel;
    end

    // R11: a held read strobe gives a single consume pulse
    a_r11_single_read: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> !data_rd);
    a_r11_single_write: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr || data_wr) |=> !(ctrl_wr || data_wr));
endmodule

// File: rtl/usart_init_fsm.sv
module usart_init_fsm
    import usart_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic irst_bit,
    output logic mode_wr,
    output logic cmd_wr,
    output logic irst_now,
    output logic irst_pulse
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_AWAIT_MODE;
            irst_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            irst_pulse <= irst_now;
        end
    end

    always_comb begin
        state_d  = state_q;
        mode_wr  = 1'b0;
        cmd_wr   = 1'b0;
        irst_now = 1'b0;
        unique case (state_q)
            SEQ_AWAIT_MODE: begin
                if (ctrl_wr) begin
                    mode_wr = 1'b1;
                    state_d = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (ctrl_wr) begin
                    if (irst_bit) begin
                        irst_now = 1'b1;
                        state_d  = SEQ_AWAIT_MODE;
                    end else begin
                        cmd_wr = 1'b1;
                    end
                end
            end
            default: state_d = SEQ_AWAIT_MODE;
        endcase
    end

    // R2: a mode capture always leads to the command phase
    a_r2_mode_then_run: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_AWAIT_MODE && ctrl_wr) |=> state_q == SEQ_RUN);
    // R3: the internal reset pulse coincides with waiting for a new mode
    a_r3_irst_awaits: assert property (@(posedge clk) disable iff (rst)
        irst_pulse |-> state_q == SEQ_AWAIT_MODE);
    a_r3_pulse_short: assert property (@(posedge clk) disable iff (rst)
        irst_pulse |=> !irst_pulse);
endmodule

// File: rtl/usart_ctrl_regs.sv
module usart_ctrl_regs
    import usart_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic              cmd_wr,
    input  logic              irst_now,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] din,
    input  logic              par_set,
    input  logic              ovr_set,
    input  logic              frm_set,
    output mode_t             mode_q,
    output cmd_t              cmd_q,
    output logic              par_flag,
    output logic              ovr_flag,
    output logic              frm_flag,
    output logic              err_clr_q,
    output logic              tx_load_q,
    output logic [BYTE_W-1:0] tx_byte_q
);
    logic err_clr_now;

    always_comb err_clr_now = (cmd_wr && din[CB_ERST]) || irst_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            cmd_q     <= '0;
            par_flag  <= 1'b0;
            ovr_flag  <= 1'b0;
            frm_flag  <= 1'b0;
            err_clr_q <= 1'b0;
            tx_load_q <= 1'b0;
            tx_byte_q <= '0;
        end else begin
            if (irst_now) begin
                mode_q <= '0;
                cmd_q  <= '0;
            end else begin
                if (mode_wr) mode_q <= mode_t'(din);
                if (cmd_wr) begin
                    cmd_q.tx_en <= din[CB_TXEN];
                    cmd_q.dtr   <= din[CB_DTR];
                    cmd_q.rx_en <= din[CB_RXEN];
                    cmd_q.brk   <= din[CB_BRK];
                    cmd_q.rts   <= din[CB_RTS];
                end
            end
            // a set in the same cycle as a clear takes priority
            par_flag  <= par_set || (par_flag && !err_clr_now);
            ovr_flag  <= ovr_set || (ovr_flag && !err_clr_now);
            frm_flag  <= frm_set || (frm_flag && !err_clr_now);
            err_clr_q <= cmd_wr && din[CB_ERST];
            tx_load_q <= data_wr;
            if (data_wr) tx_byte_q <= din;
        end
    end

    // R10: an error pulse is never lost
    a_r10_set_sticks: assert property (@(posedge clk) disable iff (rst)
        par_set |=> par_flag);
    a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
        (err_clr_now && !ovr_set && !frm_set) |=> (!ovr_flag && !frm_flag));
    // R8: data writes leave the control state alone
    a_r8_data_isolated: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> ($stable(mode_q) && $stable(cmd_q)));
endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
    import usart_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cd_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    input  logic              tx_rdy_in,
    input  logic              tx_empty_in,
    input  logic              rx_rdy_in,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              par_err_set,
    input  logic              ovr_err_set,
    input  logic              frm_err_set,
    input  logic              dsr_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              tx_en,
    output logic              rx_en,
    output logic              send_brk,
    output logic              err_clr,
    output logic              dp_rst,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_rd,
    output logic [MUL_W-1:0]  baud_mul,
    output logic [CHAR_W-1:0] char_bits,
    output logic [STOP_W-1:0] stop_halves,
    output logic              par_en,
    output logic              par_even
);
    logic ctrl_wr, data_wr, data_rd;
    logic mode_wr, cmd_wr, irst_now;
    logic par_flag, ovr_flag, frm_flag;
    mode_t mode_q;
    cmd_t  cmd_q;
    logic [BYTE_W-1:0] status;

    usart_bus_decode u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cd_sel(cd_sel),
        .rd_n(rd_n), .wr_n(wr_n),
        .ctrl_wr(ctrl_wr), .data_wr(data_wr), .data_rd(data_rd)
    );

    usart_init_fsm u_fsm (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .irst_bit(din[CB_IRST]),
        .mode_wr(mode_wr), .cmd_wr(cmd_wr), .irst_now(irst_now),
        .irst_pulse(dp_rst)
    );

    usart_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .cmd_wr(cmd_wr),
        .irst_now(irst_now), .data_wr(data_wr), .din(din),
        .par_set(par_err_set), .ovr_set(ovr_err_set), .frm_set(frm_err_set),
        .mode_q(mode_q), .cmd_q(cmd_q),
        .par_flag(par_flag), .ovr_flag(ovr_flag), .frm_flag(frm_flag),
        .err_clr_q(err_clr), .tx_load_q(tx_load), .tx_byte_q(tx_byte)
    );

    always_comb begin
        status  = {!dsr_n, 1'b0, frm_flag, ovr_flag, par_flag,
                   tx_empty_in, rx_rdy_in, tx_rdy_in};
        dout_oe = !cs_n && !rd_n && wr_n;
        dout    = '0;
        if (dout_oe) dout = cd_sel ? status : rx_byte;
        rx_rd   = data_rd;

        tx_en    = cmd_q.tx_en;
        rx_en    = cmd_q.rx_en;
        send_brk = cmd_q.brk;
        dtr_n    = !cmd_q.dtr;
        rts_n    = !cmd_q.rts;

        unique case (mode_q.fact)
            2'b00: baud_mul = MUL_W'(0);
            2'b01: baud_mul = MUL_W'(1);
            2'b10: baud_mul = MUL_W'(16);
            default: baud_mul = MUL_W'(64);
        endcase
        char_bits = CHAR_W'(MIN_CHAR) + CHAR_W'(mode_q.len);
        unique case (mode_q.stop)
            2'b11: stop_halves = STOP_W'(4);
            2'b10: stop_halves = STOP_W'(3);
            default: stop_halves = STOP_W'(2);
        endcase
        par_en   = mode_q.par;
        par_even = mode_q.even;
    end

    // R9: a deselected bus cannot alter control state
    a_r9_deselect_holds: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(mode_q) && $stable(cmd_q)));
    // R3: internal reset leaves the modem pins and enables inactive
    a_r3_pins_released: assert property (@(posedge clk) disable iff (rst)
        dp_rst |-> (dtr_n && rts_n && !tx_en && !rx_en && !send_brk));
    // R7: the consume strobe only accompanies a driven data read
    a_r7_rd_with_oe: assert property (@(posedge clk) disable iff (rst)
        rx_rd |-> (dout_oe && dout == rx_byte));
endmodule

// File: tb/usart_ctrl_seq_tb.sv
module usart_ctrl_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, cd_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = '0, rx_byte = '0;
    logic tx_rdy_in = 0, tx_empty_in = 0, rx_rdy_in = 0;
    logic par_err_set = 0, ovr_err_set = 0, frm_err_set = 0, dsr_n = 1;
    logic [7:0] dout, tx_byte;
    logic dout_oe, dtr_n, rts_n, tx_en, rx_en, send_brk, err_clr, dp_rst;
    logic tx_load, rx_rd, par_en, par_even;
    logic [6:0] baud_mul;
    logic [3:0] char_bits;
    logic [2:0] stop_halves;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    usart_ctrl_seq u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic bus_wr(logic c, logic [7:0] d);
        @(negedge clk); cs_n = 0; cd_sel = c; din = d; wr_n = 0;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    function automatic logic [31:0] mode_exp(logic [7:0] m);
        logic [6:0] b;
        logic [2:0] s;
        b = (m[1:0] == 0) ? 7'd0 : (m[1:0] == 1) ? 7'd1 : (m[1:0] == 2) ? 7'd16 : 7'd64;
        s = (m[7:6] == 3) ? 3'd4 : (m[7:6] == 2) ? 3'd3 : 3'd2;
        return {16'd0, b, 4'(5 + m[3:2]), s, m[4], m[5]};
    endfunction

    function automatic logic [31:0] mode_act();
        return {16'd0, baud_mul, char_bits, stop_halves, par_en, par_even};
    endfunction

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {dtr_n, rts_n, tx_en, rx_en, send_brk, dout_oe}, 6'b110000);

        // R4 sweep of every mode byte, each after a fresh reset
        for (int m = 0; m < 256; m++) begin
            do_reset();
            bus_wr(1, 8'(m));
            chk("R4", mode_act(), mode_exp(8'(m)));
        end
        do_reset();
        bus_wr(1, 8'hDA);
        chk("R4 0xDA", mode_act(), {16'd0, 7'd16, 4'd7, 3'd4, 1'b1, 1'b0});

        // R2 later control writes are commands
        bus_wr(1, 8'h23);
        chk("R2 cmd", {tx_en, dtr_n, rts_n}, 3'b100);
        chk("R2 mode kept", mode_act(), mode_exp(8'hDA));

        // R5 sweep over commands with bit 6 clear
        for (int v = 0; v < 256; v++) begin
            if (v[6]) continue;
            bus_wr(1, 8'(v));
            chk("R5", {tx_en, rx_en, send_brk, dtr_n, rts_n},
                {v[0], v[2], v[3], ~v[1], ~v[5]});
            chk("R10 clr pulse", err_clr, v[4]);
            chk("R2 mode stable", mode_act(), mode_exp(8'hDA));
        end

        // R3 internal reset carrying other bits
        bus_wr(1, 8'h6F);
        chk("R3 pulse", dp_rst, 1);
        chk("R3 outputs", {tx_en, rx_en, send_brk, dtr_n, rts_n}, 5'b00011);
        chk("R3 mode cleared", baud_mul, 0);
        @(negedge clk);
        chk("R3 pulse width", dp_rst, 0);
        bus_wr(1, 8'h4F);
        chk("R3 next is mode", mode_act(), mode_exp(8'h4F));
        chk("R3 no enable", tx_en, 0);
        bus_wr(1, 8'h05);
        chk("R3 then cmd", {tx_en, rx_en}, 2'b11);

        // R6 status sweep
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            tx_rdy_in = k[0]; rx_rdy_in = k[1]; tx_empty_in = k[2]; dsr_n = k[3];
            cs_n = 0; cd_sel = 1; rd_n = 0;
            #1;
            chk("R6", {dout_oe, dout}, {1'b1, ~k[3], 4'b0000, k[2], k[1], k[0]});
            @(negedge clk); cs_n = 1; rd_n = 1;
        end
        tx_rdy_in = 0; rx_rdy_in = 0; tx_empty_in = 0; dsr_n = 1;

        // R10 flags and same-cycle set versus clear
        @(negedge clk); par_err_set = 1; ovr_err_set = 1; frm_err_set = 1;
        @(negedge clk); par_err_set = 0; ovr_err_set = 0; frm_err_set = 0;
        @(negedge clk); cs_n = 0; cd_sel = 1; rd_n = 0; #1;
        chk("R10 set", dout[5:3], 3'b111);
        @(negedge clk); cs_n = 1; rd_n = 1;
        @(negedge clk); cs_n = 0; cd_sel = 1; din = 8'h15; wr_n = 0; par_err_set = 1;
        @(negedge clk); cs_n = 1; wr_n = 1; par_err_set = 0;
        chk("R10 pulse", err_clr, 1);
        @(negedge clk); cs_n = 0; cd_sel = 1; rd_n = 0; #1;
        chk("R10 set wins", dout[5:3], 3'b001);
        @(negedge clk); cs_n = 1; rd_n = 1;
        bus_wr(1, 8'h15);
        @(negedge clk); cs_n = 0; cd_sel = 1; rd_n = 0; #1;
        chk("R10 cleared", dout[5:3], 3'b000);
        @(negedge clk); cs_n = 1; rd_n = 1;

        // R7 and R11 data read held two cycles
        rx_byte = 8'hA5;
        @(negedge clk); cs_n = 0; cd_sel = 0; rd_n = 0; #1;
        chk("R7 data", {dout_oe, dout}, 9'h1A5);
        chk("R7 rx_rd", rx_rd, 1);
        @(negedge clk); #1;
        chk("R11 single rd", rx_rd, 0);
        chk("R7 data held", dout, 8'hA5);
        @(negedge clk); cs_n = 1; rd_n = 1;

        // R8 data write
        bus_wr(0, 8'h3C);
        chk("R8 load", {tx_load, tx_byte}, 9'h13C);
        chk("R8 cmd kept", {tx_en, rx_en}, 2'b11);
        chk("R8 mode kept", mode_act(), mode_exp(8'h4F));
        @(negedge clk);
        chk("R8 pulse", tx_load, 0);

        // R11 held write strobe
        pulses = 0;
        @(negedge clk); cs_n = 0; cd_sel = 0; din = 8'h77; wr_n = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (tx_load) pulses++;
        end
        cs_n = 1; wr_n = 1;
        @(negedge clk); if (tx_load) pulses++;
        chk("R11 single wr", pulses, 1);

        // R9 deselected strobes
        pulses = 0;
        @(negedge clk); cs_n = 1; cd_sel = 1; din = 8'h00; wr_n = 0; rd_n = 0; #1;
        chk("R9 oe", dout_oe, 0);
        chk("R9 rx_rd", rx_rd, 0);
        @(negedge clk); cd_sel = 0;
        @(negedge clk); if (tx_load) pulses++;
        wr_n = 1; rd_n = 1;
        @(negedge clk); if (tx_load) pulses++;
        chk("R9 no load", pulses, 0);
        chk("R9 cmd kept", {tx_en, rx_en}, 2'b11);
        chk("R9 mode kept", mode_act(), mode_exp(8'h4F));

        // R1 hardware reset from running state
        do_reset();
        @(negedge clk);
        chk("R1 after run", {dtr_n, rts_n, tx_en, rx_en, send_brk, baud_mul}, {5'b11000, 7'd0});
        bus_wr(1, 8'hDA);
        chk("R1 awaits mode", mode_act(), mode_exp(8'hDA));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule